// File: doc/BRIEF.md
# Blocked Vector-Matrix Engine with Requantization

This engine computes one fully connected layer for a single input row. It multiplies an input vector by a weight matrix, rescales every 32-bit dot product back to 8 bits and writes the results to an output memory. The on-chip accumulator storage covers only one block of outputs. The engine therefore runs one output block at a time: it zeroes that block, sweeps the whole input vector across it, writes the block back, and then moves on to the next block.

Inside a block the multiply-accumulate work is split into square tiles. All rows of a tile run in parallel lanes. Each cycle one input element is broadcast to every lane, together with one weight column. Each finished sum is shifted right arithmetically by the input element width. The result is clamped to the range from zero to the largest positive value of the input type, which acts as a ReLU, and is then narrowed to the input type. A single start pulse launches a full pass. A one-cycle done pulse reports that the last result has been written.

Top module: `gemv_tiled`

## Requirements
- R1: After reset, done, x_re, w_re and out_we are all low.
- R2: A start pulse while idle runs a complete pass. For every output index j, out_data = clamp((sum over i of x[i]*W[j][i]) >>> DW), and each j is written exactly once.
- R3: The weight read word at w_addr = (ot*N_IT + it)*TILE + k holds, in lane r at bits [r*DW +: DW], the weight W[ot*TILE+r][it*TILE+k]. N_IT is IN_LEN/TILE. The memory returns that word in the cycle after w_re.
- R4: The input read at x_addr = it*TILE + k returns x[it*TILE+k] in the cycle after x_re.
- R5: Results are written in ascending out_addr order, one block of BLK_TILES*TILE outputs after another. Consecutive write cycles increase out_addr by exactly one.
- R6: A sum that is negative after the arithmetic shift gives 0.
- R7: A shifted sum above 2^(DW-1)-1 gives 2^(DW-1)-1 (127 for DW=8).
- R8: The products are sign-extended before they are summed. A sum far above 2^15, such as many products of -128 by -128, is formed at the full accumulator width.
- R9: done is high for exactly one cycle, in the cycle directly after the last write of the pass.
- R10: A start pulse during a pass has no effect. The write sequence is unchanged and only one done pulse appears.
- R11: A new start after done recomputes everything from zeroed accumulators. Nothing is left over from the previous pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a pass when idle |
| done | output | 1 | One-cycle pulse after the final write |
| x_re | output | 1 | Input vector read enable |
| x_addr | output | clog2(IN_LEN) | Input vector element address |
| x_data | input | DW | Input element, valid one cycle after x_re |
| w_re | output | 1 | Weight read enable |
| w_addr | output | clog2(OUT_LEN*IN_LEN/TILE) | Weight column word address |
| w_data | input | TILE*DW | TILE weights, one per lane, valid one cycle after w_re |
| out_we | output | 1 | Output write enable |
| out_addr | output | clog2(OUT_LEN) | Output element address |
| out_data | output | DW | Requantized result |

## Verification
The bench builds the engine with IN_LEN=32, OUT_LEN=32, TILE=4 and BLK_TILES=2. This gives four outer output blocks by four outer input blocks, each two tiles wide. Every transition of the loop nest is therefore reached: the last element of a tile, the last tile of a block, the last input block and the last output block. The change from writing one block to clearing the next also happens several times per pass. With these sizes a pass is short enough to repeat under several data patterns, including saturating sums, negative sums, start pulses in mid-pass and a rerun with new data.

// File: rtl/gemv_pkg.sv
package gemv_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLR,
        S_MAC,
        S_DRN,
        S_WR,
        S_DONE
    } seq_state_e;

    function automatic int cw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gemv_seq.sv
module gemv_seq
    import gemv_pkg::*;
#(
    parameter int IN_LEN    = 1024,
    parameter int OUT_LEN   = 1024,
    parameter int TILE      = 16,
    parameter int BLK_TILES = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    output logic                            rd_en,
    output logic [cw(IN_LEN)-1:0]           x_addr,
    output logic [cw(OUT_LEN/TILE*IN_LEN)-1:0] w_addr,
    output logic [cw(BLK_TILES)-1:0]        mac_tile,
    output logic                            clr,
    output logic                            wr_en,
    output logic [cw(BLK_TILES*TILE)-1:0]   wr_idx,
    output logic [cw(OUT_LEN)-1:0]          out_addr,
    output logic                            done
);
    localparam int N_IT  = IN_LEN / TILE;
    localparam int N_OT  = OUT_LEN / TILE;
    localparam int N_IB  = N_IT / BLK_TILES;
    localparam int N_OB  = N_OT / BLK_TILES;
    localparam int BLK_N = BLK_TILES * TILE;
    localparam int OBW   = cw(N_OB);
    localparam int IBW   = cw(N_IB);
    localparam int TW    = cw(BLK_TILES);
    localparam int KW    = cw(TILE);
    localparam int WIW   = cw(BLK_N);
    localparam int ITW   = cw(N_IT);
    localparam int OTW   = cw(N_OT);
    localparam int XAW   = cw(IN_LEN);
    localparam int WAW   = cw(N_OT * IN_LEN);
    localparam int OAW   = cw(OUT_LEN);

    typedef struct packed {
        seq_state_e       st;
        logic [OBW-1:0]   ob;
        logic [IBW-1:0]   ib;
        logic [TW-1:0]    oti;
        logic [TW-1:0]    iti;
        logic [KW-1:0]    k;
        logic [WIW-1:0]   widx;
    } seq_t;

    seq_t s_q, s_d;

    logic k_last, iti_last, oti_last, ib_last, ob_last, widx_last;

    always_comb begin
        k_last    = (s_q.k    == KW'(TILE - 1));
        iti_last  = (s_q.iti  == TW'(BLK_TILES - 1));
        oti_last  = (s_q.oti  == TW'(BLK_TILES - 1));
        ib_last   = (s_q.ib   == IBW'(N_IB - 1));
        ob_last   = (s_q.ob   == OBW'(N_OB - 1));
        widx_last = (s_q.widx == WIW'(BLK_N - 1));

        s_d = s_q;
        unique case (s_q.st)
            S_IDLE: begin
                if (start) begin
                    s_d.st = S_CLR;
                    s_d.ob = '0;
                end
            end
            S_CLR: begin
                s_d.st  = S_MAC;
                s_d.ib  = '0;
                s_d.oti = '0;
                s_d.iti = '0;
                s_d.k   = '0;
            end
            S_MAC: begin
                s_d.k = s_q.k + 1'b1;
                if (k_last) begin
                    s_d.k   = '0;
                    s_d.iti = s_q.iti + 1'b1;
                    if (iti_last) begin
                        s_d.iti = '0;
                        s_d.oti = s_q.oti + 1'b1;
                        if (oti_last) begin
                            s_d.oti = '0;
                            s_d.ib  = s_q.ib + 1'b1;
                            if (ib_last) begin
                                s_d.ib = '0;
                                s_d.st = S_DRN;
                            end
                        end
                    end
                end
            end
            S_DRN: begin
                s_d.st   = S_WR;
                s_d.widx = '0;
            end
            S_WR: begin
                s_d.widx = s_q.widx + 1'b1;
                if (widx_last) begin
                    s_d.widx = '0;
                    if (ob_last) begin
                        s_d.st = S_DONE;
                    end else begin
                        s_d.ob = s_q.ob + 1'b1;
                        s_d.st = S_CLR;
                    end
                end
            end
            S_DONE:  s_d.st = S_IDLE;
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: S_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    logic [ITW-1:0] it_glob;
    logic [OTW-1:0] ot_glob;

    always_comb begin
        it_glob  = ITW'(s_q.ib) * ITW'(BLK_TILES) + ITW'(s_q.iti);
        ot_glob  = OTW'(s_q.ob) * OTW'(BLK_TILES) + OTW'(s_q.oti);
        x_addr   = XAW'(it_glob) * XAW'(TILE) + XAW'(s_q.k);
        w_addr   = (WAW'(ot_glob) * WAW'(N_IT) + WAW'(it_glob)) * WAW'(TILE) + WAW'(s_q.k);
        out_addr = OAW'(s_q.ob) * OAW'(BLK_N) + OAW'(s_q.widx);
        rd_en    = (s_q.st == S_MAC);
        mac_tile = s_q.oti;
        clr      = (s_q.st == S_CLR);
        wr_en    = (s_q.st == S_WR);
        wr_idx   = s_q.widx;
        done     = (s_q.st == S_DONE);
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_en));

    // R5
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (out_addr == $past(out_addr) + 1'b1));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && start) |=> (rd_en || s_q.st == S_DRN));

endmodule

// File: rtl/gemv_lanes.sv
module gemv_lanes
    import gemv_pkg::*;
#(
    parameter int TILE      = 16,
    parameter int BLK_TILES = 16,
    parameter int DW        = 8,
    parameter int AW        = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           mac_vld,
    input  logic [cw(BLK_TILES)-1:0]       mac_tile,
    input  logic [DW-1:0]                  x_data,
    input  logic [TILE*DW-1:0]             w_data,
    input  logic                           rd_en,
    input  logic [cw(BLK_TILES*TILE)-1:0]  rd_idx,
    output logic [AW-1:0]                  rd_acc
);
    localparam int BLK_N = BLK_TILES * TILE;
    localparam int TW    = cw(BLK_TILES);
    localparam int BIW   = cw(BLK_N);

    typedef struct packed {
        logic                      vld;
        logic [TW-1:0]             tile;
        logic [BLK_N-1:0][AW-1:0]  acc;
    } lane_t;

    lane_t l_q, l_d;

    logic signed [AW-1:0] prod [TILE];

    for (genvar r = 0; r < TILE; r++) begin : g_lane
        assign prod[r] = AW'($signed(x_data)) * AW'($signed(w_data[r*DW +: DW]));
    end

    always_comb begin
        l_d      = l_q;
        l_d.vld  = mac_vld;
        l_d.tile = mac_tile;
        if (clr) begin
            l_d.acc = '0;
        end else if (l_q.vld) begin
            for (int r = 0; r < TILE; r++) begin
                l_d.acc[BIW'(l_q.tile) * BIW'(TILE) + BIW'(r)] =
                    l_q.acc[BIW'(l_q.tile) * BIW'(TILE) + BIW'(r)] + prod[r];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign rd_acc = l_q.acc[rd_idx];

    // R11
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !l_q.vld);

    // R5
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (!l_q.vld && !mac_vld));

endmodule

// File: rtl/gemv_requant.sv
module gemv_requant #(
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic [AW-1:0] acc_in,
    output logic [DW-1:0] q_out
);
    localparam logic signed [AW-1:0] QMAX = AW'((1 << (DW - 1)) - 1);

    logic signed [AW-1:0] shifted;

    always_comb begin
        shifted = $signed(acc_in) >>> DW;
        if (shifted < 0) begin
            q_out = '0;
        end else if (shifted > QMAX) begin
            q_out = QMAX[DW-1:0];
        end else begin
            q_out = shifted[DW-1:0];
        end
    end

endmodule

// File: rtl/gemv_tiled.sv
module gemv_tiled
    import gemv_pkg::*;
#(
    parameter int IN_LEN    = 1024,
    parameter int OUT_LEN   = 1024,
    parameter int TILE      = 16,
    parameter int BLK_TILES = 16,
    parameter int DW        = 8,
    parameter int AW        = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    output logic                                 done,
    output logic                                 x_re,
    output logic [cw(IN_LEN)-1:0]                x_addr,
    input  logic [DW-1:0]                        x_data,
    output logic                                 w_re,
    output logic [cw(OUT_LEN/TILE*IN_LEN)-1:0]   w_addr,
    input  logic [TILE*DW-1:0]                   w_data,
    output logic                                 out_we,
    output logic [cw(OUT_LEN)-1:0]               out_addr,
    output logic [DW-1:0]                        out_data
);
    localparam int TW  = cw(BLK_TILES);
    localparam int WIW = cw(BLK_TILES * TILE);

    logic           rd_en;
    logic [TW-1:0]  mac_tile;
    logic           clr;
    logic           wr_en;
    logic [WIW-1:0] wr_idx;
    logic [AW-1:0]  rd_acc;

    gemv_seq #(
        .IN_LEN    (IN_LEN),
        .OUT_LEN   (OUT_LEN),
        .TILE      (TILE),
        .BLK_TILES (BLK_TILES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_en    (rd_en),
        .x_addr   (x_addr),
        .w_addr   (w_addr),
        .mac_tile (mac_tile),
        .clr      (clr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .out_addr (out_addr),
        .done     (done)
    );

    gemv_lanes #(
        .TILE      (TILE),
        .BLK_TILES (BLK_TILES),
        .DW        (DW),
        .AW        (AW)
    ) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .mac_vld  (rd_en),
        .mac_tile (mac_tile),
        .x_data   (x_data),
        .w_data   (w_data),
        .rd_en    (wr_en),
        .rd_idx   (wr_idx),
        .rd_acc   (rd_acc)
    );

    gemv_requant #(
        .DW (DW),
        .AW (AW)
    ) u_rq (
        .acc_in (rd_acc),
        .q_out  (out_data)
    );

    assign x_re   = rd_en;
    assign w_re   = rd_en;
    assign out_we = wr_en;

endmodule

// File: tb/tb_gemv_tiled.sv
module tb_gemv_tiled;
    localparam int IN_LEN    = 32;
    localparam int OUT_LEN   = 32;
    localparam int TILE      = 4;
    localparam int BLK_TILES = 2;
    localparam int DW        = 8;
    localparam int AW        = 32;
    localparam int N_IT      = IN_LEN / TILE;
    localparam int N_OT      = OUT_LEN / TILE;
    localparam int NW        = N_OT * N_IT * TILE;
    localparam int XAW       = $clog2(IN_LEN);
    localparam int WAW       = $clog2(NW);
    localparam int OAW       = $clog2(OUT_LEN);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               done;
    logic               x_re;
    logic [XAW-1:0]     x_addr;
    logic [DW-1:0]      x_data = '0;
    logic               w_re;
    logic [WAW-1:0]     w_addr;
    logic [TILE*DW-1:0] w_data = '0;
    logic               out_we;
    logic [OAW-1:0]     out_addr;
    logic [DW-1:0]      out_data;

    always #10 clk = ~clk;

    gemv_tiled #(
        .IN_LEN    (IN_LEN),
        .OUT_LEN   (OUT_LEN),
        .TILE      (TILE),
        .BLK_TILES (BLK_TILES),
        .DW        (DW),
        .AW        (AW)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .done     (done),
        .x_re     (x_re),
        .x_addr   (x_addr),
        .x_data   (x_data),
        .w_re     (w_re),
        .w_addr   (w_addr),
        .w_data   (w_data),
        .out_we   (out_we),
        .out_addr (out_addr),
        .out_data (out_data)
    );

    logic [DW-1:0]      xmem [IN_LEN];
    logic [TILE*DW-1:0] wmem [NW];
    int xv [IN_LEN];
    int wv [OUT_LEN][IN_LEN];

    // R3 R4: memories answer one cycle after the read enable
    always @(posedge clk) begin
        if (x_re) x_data <= xmem[x_addr];
        if (w_re) w_data <= wmem[w_addr];
    end

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    int cyc = 0;
    bit last_we = 1'b0;
    string cur_tag = "R2";
    int exp_addr [$];
    int exp_data [$];
    int seed = 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: pop the scoreboard on every write
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_we) begin
                if (exp_addr.size() == 0) begin
                    check(1'b0, "R5 write beyond expected", int'(out_addr), -1);
                end else begin
                    int ea, ed;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    check(int'(out_addr) == ea, "R5 address order", int'(out_addr), ea);
                    check(int'(out_data) == ed, cur_tag, int'(out_data), ed);
                end
            end
            if (done) begin
                done_cnt++;
                // R9: directly after the final write
                check(last_we && exp_addr.size() == 0, "R9 done timing",
                      int'(last_we), 1);
            end
            last_we = out_we;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int rnd8();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 255) - 128;
    endfunction

    // driver: build memories (R3 R4 layout) and push expected results
    task automatic load_and_expect();
        for (int ot = 0; ot < N_OT; ot++)
            for (int it = 0; it < N_IT; it++)
                for (int k = 0; k < TILE; k++)
                    for (int r = 0; r < TILE; r++)
                        wmem[(ot*N_IT + it)*TILE + k][r*DW +: DW] =
                            DW'(wv[ot*TILE + r][it*TILE + k]);
        for (int i = 0; i < IN_LEN; i++) xmem[i] = DW'(xv[i]);
        for (int o = 0; o < OUT_LEN; o++) begin
            longint s;
            longint q;
            s = 0;
            for (int i = 0; i < IN_LEN; i++) s += longint'(xv[i]) * longint'(wv[o][i]);
            q = s >>> DW;
            if (q < 0) q = 0;
            if (q > 127) q = 127;
            exp_addr.push_back(o);
            exp_data.push_back(int'(q));
        end
    endtask

    task automatic run_pass(input string tag, input bit noisy);
        int wait_c;
        cur_tag = tag;
        load_and_expect();
        done_cnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (noisy) begin
            // R10: extra starts during the pass
            repeat (12) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (60) @(negedge clk);
            start = 1'b1;
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        wait_c = 0;
        while (done_cnt == 0 && wait_c < 5000) begin
            @(negedge clk);
            wait_c++;
        end
        repeat (4) @(negedge clk);
        check(done_cnt == 1, noisy ? "R10 single done" : "R9 single done", done_cnt, 1);
        check(exp_addr.size() == 0, "R2 all outputs written", exp_addr.size(), 0);
        check(!out_we && !x_re, "R10 idle after pass", int'(out_we), 0);
        exp_addr.delete();
        exp_data.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!done && !x_re && !w_re && !out_we, "R1 reset outputs",
              int'({done, x_re, w_re, out_we}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && !x_re && !w_re && !out_we, "R1 idle after reset",
              int'({done, x_re, w_re, out_we}), 0);

        // R2 R3 R4: pseudo-random data, with stray starts for R10
        seed = 7;
        for (int i = 0; i < IN_LEN; i++) xv[i] = rnd8();
        for (int o = 0; o < OUT_LEN; o++)
            for (int i = 0; i < IN_LEN; i++) wv[o][i] = rnd8();
        run_pass("R2 R3 R4 random data", 1'b1);

        // R7 R8: saturating positive sums, R6 large negative sums
        for (int i = 0; i < IN_LEN; i++) xv[i] = -128;
        for (int o = 0; o < OUT_LEN; o++)
            for (int i = 0; i < IN_LEN; i++) wv[o][i] = (o % 2 == 0) ? -128 : 127;
        run_pass("R7 R8 R6 saturation", 1'b0);

        // R6: row-dependent sign, negatives go to zero
        for (int i = 0; i < IN_LEN; i++) xv[i] = 16;
        for (int o = 0; o < OUT_LEN; o++)
            for (int i = 0; i < IN_LEN; i++) wv[o][i] = o - 16;
        run_pass("R6 shift and lower clamp", 1'b0);

        // R11: fresh pass with new data after done
        seed = 99;
        for (int i = 0; i < IN_LEN; i++) xv[i] = rnd8();
        for (int o = 0; o < OUT_LEN; o++)
            for (int i = 0; i < IN_LEN; i++) wv[o][i] = rnd8();
        run_pass("R11 restart from zero", 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule